// File: doc/BRIEF.md
# Bridge Posted-Write Ordering Controller

This block decides, for a bridge with one posted-write queue in each direction, whether a read must wait until posted writes have drained. A read from the processor side can be held with wait states, or it can be answered with a retry. A read from the PCI side can be answered with a retry. Each of these outcomes is governed by its own enable. All three enables are independent. Only with both flush enables set does the bridge fully order reads behind writes in both directions.

PCI-originated posted writes are counted from the moment the PCI slave commits to them, not from the moment their data is enqueued. A commit pulse raises the count and a completion pulse lowers it. A processor read under the processor-side enable is stalled while the PCI-bound queue holds data or while any committed PCI write is still outstanding. A PCI read under the PCI-side enable is retried until the PCI-bound queue reports empty. Every output is a register, so each decision appears one cycle after the inputs it depends on.

Top module: `wfb_order_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cpu_wait`, `cpu_retry` and `pci_retry` are 0 and `pend_cnt` is 0. All three enables are inputs that the bench holds at 0 during reset.
- R2: `pend_cnt` rises by one in the cycle after a `slv_commit` pulse that has no `wr_done` beside it. It falls by one after a `wr_done` pulse that has no `slv_commit` beside it. It is unchanged when both pulses arrive together or when neither arrives.
- R3: With `cfg_cpu_flush` = 1 and no retry applying, a `cpu_rd_req` sampled while `p2x_empty` = 0 gives `cpu_wait` = 1 in the next cycle.
- R4: With `cfg_cpu_flush` = 1 and no retry applying, a `cpu_rd_req` sampled while `pend_cnt` is nonzero gives `cpu_wait` = 1 in the next cycle, even with `p2x_empty` = 1.
- R5: With `cfg_retry_all` = 1, a `cpu_rd_req` sampled while `pend_cnt` is nonzero gives `cpu_retry` = 1 in the next cycle. `cpu_wait` is 0 in that cycle whatever the other enables are.
- R6: With `cfg_pci_flush` = 1, a `pci_rd_req` sampled while `p2x_empty` = 0 sets `pci_retry` in the next cycle. It then stays 1, even after the request drops, until the cycle after `p2x_empty` is sampled as 1.
- R7: `cfg_pci_flush` has no effect on `cpu_wait` or `cpu_retry`. `cfg_cpu_flush` and `cfg_retry_all` have no effect on `pci_retry`.
- R8: With all three enables at 0, `cpu_wait`, `cpu_retry` and `pci_retry` stay 0 for any mix of requests, queue flags and write pulses.
- R9: A processor read sampled in the same cycle that `p2x_empty` becomes 1, with `pend_cnt` at zero, proceeds: `cpu_wait` is 0 in the next cycle.
- R10: Clearing an enable while its stall or retry is active removes that output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpu_flush | input | 1 | Enable: stall processor reads until writes drain |
| cfg_pci_flush | input | 1 | Enable: retry PCI reads until the PCI-bound queue is empty |
| cfg_retry_all | input | 1 | Enable: retry processor reads while PCI writes are outstanding |
| cpu_rd_req | input | 1 | Processor-side read request |
| pci_rd_req | input | 1 | PCI-side read request |
| p2x_empty | input | 1 | PCI-bound posted-write queue is empty |
| slv_commit | input | 1 | PCI slave committed to a posted write (one pulse per write) |
| wr_done | input | 1 | One posted PCI write completed (one pulse per write) |
| cpu_wait | output | 1 | Insert wait states on the processor read |
| cpu_retry | output | 1 | Retry the processor read |
| pci_retry | output | 1 | Retry the PCI read |
| pend_cnt | output | CNT_W | Number of outstanding committed PCI posted writes |

## Verification
The assertions take for granted that `wr_done` never arrives alone while the count is zero. They also take for granted that `slv_commit` never arrives alone while the count is at its maximum, so the counter neither wraps nor saturates in use. The random stimulus tracks its own count of outstanding writes. It issues a completion only when that count is nonzero, and it suppresses commits once the count nears the top of the range. Enables, requests and the queue flag are drawn freely and changed in blocks of cycles, so every policy mix is covered.

// File: rtl/wfb_pkg.sv
package wfb_pkg;

    localparam int unsigned CNT_W_DEF = 4;

    typedef struct packed {
        logic cpu_flush;
        logic pci_flush;
        logic retry_all;
    } wfb_cfg_t;

    typedef struct packed {
        logic wait_st;
        logic retry;
    } cpu_resp_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'b00,
        CNT_UP   = 2'b01,
        CNT_DOWN = 2'b10
    } cnt_op_e;

    function automatic cnt_op_e cnt_op(input logic inc, input logic dec);
        if (inc && !dec) return CNT_UP;
        if (dec && !inc) return CNT_DOWN;
        return CNT_HOLD;
    endfunction

endpackage

// File: rtl/wfb_pend_cnt.sv
module wfb_pend_cnt
    import wfb_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_i,
    input  logic             done_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    cnt_op_e          op;

    assign op = cnt_op(commit_i, done_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_UP:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
                CNT_DOWN: if (cnt_q != '0)      cnt_q <= cnt_q - CNT_ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign busy_o = (cnt_q != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !done_i) |-> (cnt_q != CNT_MAX)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (done_i && !commit_i) |-> (cnt_q != '0)); // R2
    AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !done_i) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R2
    AST_CNT_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (commit_i && done_i) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/wfb_cpu_path.sv
module wfb_cpu_path
    import wfb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wfb_cfg_t  cfg_i,
    input  logic      rd_req_i,
    input  logic      p2x_empty_i,
    input  logic      pend_busy_i,
    output cpu_resp_t resp_o
);
    cpu_resp_t resp_d, resp_q;
    logic      must_retry;
    logic      must_stall;

    always_comb begin
        must_retry     = cfg_i.retry_all & pend_busy_i;
        must_stall     = cfg_i.cpu_flush & (~p2x_empty_i | pend_busy_i);
        resp_d.retry   = rd_req_i & must_retry;
        resp_d.wait_st = rd_req_i & must_stall & ~must_retry;
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign resp_o = resp_q;

    AST_RETRY_OVER_WAIT: assert property (@(posedge clk) disable iff (rst)
        !(resp_q.wait_st && resp_q.retry)); // R5
    AST_CPU_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.cpu_flush && !cfg_i.retry_all) |=> (resp_q == '0)); // R8
    AST_CPU_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !rd_req_i |=> (resp_q == '0)); // R3

endmodule

// File: rtl/wfb_pci_path.sv
module wfb_pci_path
    import wfb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wfb_cfg_t cfg_i,
    input  logic     rd_req_i,
    input  logic     p2x_empty_i,
    output logic     retry_o
);
    logic retry_q;
    logic retry_d;

    always_comb begin
        retry_d = cfg_i.pci_flush & ~p2x_empty_i & (rd_req_i | retry_q);
    end

    always_ff @(posedge clk) begin
        if (rst) retry_q <= 1'b0;
        else     retry_q <= retry_d;
    end

    assign retry_o = retry_q;

    AST_PCI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (retry_q && cfg_i.pci_flush && !p2x_empty_i) |=> retry_q); // R6
    AST_PCI_RELEASE: assert property (@(posedge clk) disable iff (rst)
        p2x_empty_i |=> !retry_q); // R6
    AST_PCI_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.pci_flush |=> !retry_q); // R10

endmodule

// File: rtl/wfb_order_ctrl.sv
module wfb_order_ctrl
    import wfb_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cpu_flush,
    input  logic             cfg_pci_flush,
    input  logic             cfg_retry_all,
    input  logic             cpu_rd_req,
    input  logic             pci_rd_req,
    input  logic             p2x_empty,
    input  logic             slv_commit,
    input  logic             wr_done,
    output logic             cpu_wait,
    output logic             cpu_retry,
    output logic             pci_retry,
    output logic [CNT_W-1:0] pend_cnt
);
    wfb_cfg_t  cfg;
    cpu_resp_t cpu_resp;
    logic      pend_busy;

    assign cfg.cpu_flush = cfg_cpu_flush;
    assign cfg.pci_flush = cfg_pci_flush;
    assign cfg.retry_all = cfg_retry_all;

    wfb_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .commit_i (slv_commit),
        .done_i   (wr_done),
        .cnt_o    (pend_cnt),
        .busy_o   (pend_busy)
    );

    wfb_cpu_path u_cpu (
        .clk         (clk),
        .rst         (rst),
        .cfg_i       (cfg),
        .rd_req_i    (cpu_rd_req),
        .p2x_empty_i (p2x_empty),
        .pend_busy_i (pend_busy),
        .resp_o      (cpu_resp)
    );

    wfb_pci_path u_pci (
        .clk         (clk),
        .rst         (rst),
        .cfg_i       (cfg),
        .rd_req_i    (pci_rd_req),
        .p2x_empty_i (p2x_empty),
        .retry_o     (pci_retry)
    );

    assign cpu_wait  = cpu_resp.wait_st;
    assign cpu_retry = cpu_resp.retry;

    AST_CPU_IGNORES_PCI_EN: assert property (@(posedge clk) disable iff (rst)
        (!cfg_cpu_flush && !cfg_retry_all && cfg_pci_flush) |=> (!cpu_wait && !cpu_retry)); // R7
    AST_PCI_IGNORES_CPU_EN: assert property (@(posedge clk) disable iff (rst)
        !cfg_pci_flush |=> !pci_retry); // R7

endmodule

// File: tb/wfb_order_ctrl_bench.sv
module wfb_order_ctrl_bench;
    localparam int unsigned CNT_W = 4;
    localparam int unsigned CNT_CAP = 13;

    logic clk = 1'b0;
    logic rst;
    logic cfg_cpu_flush, cfg_pci_flush, cfg_retry_all;
    logic cpu_rd_req, pci_rd_req, p2x_empty, slv_commit, wr_done;
    logic cpu_wait, cpu_retry, pci_retry;
    logic [CNT_W-1:0] pend_cnt;

    int checks = 0;
    int errors = 0;
    int m_cnt  = 0;
    logic m_pci = 1'b0;
    logic e_wait, e_retry, e_pci;

    always #2.5 clk = ~clk;

    wfb_order_ctrl #(.CNT_W(CNT_W)) u_wfb_order_ctrl (
        .clk(clk), .rst(rst),
        .cfg_cpu_flush(cfg_cpu_flush), .cfg_pci_flush(cfg_pci_flush),
        .cfg_retry_all(cfg_retry_all),
        .cpu_rd_req(cpu_rd_req), .pci_rd_req(pci_rd_req), .p2x_empty(p2x_empty),
        .slv_commit(slv_commit), .wr_done(wr_done),
        .cpu_wait(cpu_wait), .cpu_retry(cpu_retry), .pci_retry(pci_retry),
        .pend_cnt(pend_cnt)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_retry(logic req, logic en, int cnt);
        return req & en & (cnt != 0);
    endfunction

    function automatic logic exp_wait(logic req, logic en, logic ret, logic empty, int cnt);
        return req & en & ~ret & (~empty | (cnt != 0));
    endfunction

    function automatic logic exp_pci(logic req, logic en, logic empty, logic held);
        return en & ~empty & (req | held);
    endfunction

    function automatic int next_cnt(int cnt, logic c, logic d);
        if (c && !d) return cnt + 1;
        if (d && !c) return cnt - 1;
        return cnt;
    endfunction

    // Called at a falling edge after inputs are set; checks outputs one cycle later.
    task automatic step();
        e_retry = exp_retry(cpu_rd_req, cfg_retry_all, m_cnt);
        e_wait  = exp_wait(cpu_rd_req, cfg_cpu_flush, e_retry, p2x_empty, m_cnt);
        e_pci   = exp_pci(pci_rd_req, cfg_pci_flush, p2x_empty, m_pci);
        m_cnt   = next_cnt(m_cnt, slv_commit, wr_done);
        m_pci   = e_pci;
        @(posedge clk);
        @(negedge clk);
        check("R2", "pend_cnt", int'(pend_cnt), m_cnt);
        check("R3", "cpu_wait", int'(cpu_wait), int'(e_wait));
        check("R5", "cpu_retry", int'(cpu_retry), int'(e_retry));
        check("R6", "pci_retry", int'(pci_retry), int'(e_pci));
        slv_commit = 1'b0;
        wr_done    = 1'b0;
    endtask

    task automatic set_cfg(input logic c, input logic p, input logic r);
        cfg_cpu_flush = c;
        cfg_pci_flush = p;
        cfg_retry_all = r;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_cfg(0, 0, 0);
        cpu_rd_req = 0; pci_rd_req = 0; p2x_empty = 1; slv_commit = 0; wr_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "cpu_wait", int'(cpu_wait), 0);
        check("R1", "cpu_retry", int'(cpu_retry), 0);
        check("R1", "pci_retry", int'(pci_retry), 0);
        check("R1", "pend_cnt", int'(pend_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "cpu_wait after release", int'(cpu_wait), 0);
        check("R1", "pend_cnt after release", int'(pend_cnt), 0);

        // R8: all enables clear
        cpu_rd_req = 1; pci_rd_req = 1; p2x_empty = 0; slv_commit = 1;
        step();
        step();
        check("R8", "cpu_wait", int'(cpu_wait), 0);
        check("R8", "cpu_retry", int'(cpu_retry), 0);
        check("R8", "pci_retry", int'(pci_retry), 0);

        // R4: count nonzero stalls even with empty queue
        set_cfg(1, 0, 0);
        p2x_empty = 1; pci_rd_req = 0;
        step();
        check("R4", "cpu_wait count pending", int'(cpu_wait), 1);
        wr_done = 1;
        step();
        check("R2", "pend_cnt back to zero", int'(pend_cnt), 0);
        step();
        check("R4", "cpu_wait after drain", int'(cpu_wait), 0);

        // R9: queue empties in the request cycle
        p2x_empty = 0;
        step();
        check("R3", "cpu_wait queue busy", int'(cpu_wait), 1);
        p2x_empty = 1;
        step();
        check("R9", "cpu_wait same cycle empty", int'(cpu_wait), 0);

        // R2: simultaneous pulses
        slv_commit = 1;
        step();
        slv_commit = 1; wr_done = 1;
        step();
        check("R2", "pend_cnt both pulses", int'(pend_cnt), 1);

        // R5: retry beats wait
        set_cfg(1, 0, 1);
        p2x_empty = 0;
        step();
        check("R5", "cpu_retry", int'(cpu_retry), 1);
        check("R5", "cpu_wait suppressed", int'(cpu_wait), 0);

        // R10: clearing enable drops stall
        set_cfg(1, 0, 0);
        step();
        check("R10", "cpu_wait active", int'(cpu_wait), 1);
        set_cfg(0, 0, 0);
        step();
        check("R10", "cpu_wait cleared", int'(cpu_wait), 0);

        // R7: pci enable does not touch processor outputs
        set_cfg(0, 1, 0);
        cpu_rd_req = 1; pci_rd_req = 1; p2x_empty = 0;
        step();
        check("R7", "cpu_wait with only pci enable", int'(cpu_wait), 0);
        check("R6", "pci_retry set", int'(pci_retry), 1);
        pci_rd_req = 0;
        step();
        check("R6", "pci_retry held", int'(pci_retry), 1);
        p2x_empty = 1;
        step();
        check("R6", "pci_retry released", int'(pci_retry), 0);
        set_cfg(1, 0, 1);
        pci_rd_req = 1; p2x_empty = 0;
        step();
        check("R7", "pci_retry with only cpu enables", int'(pci_retry), 0);

        wr_done = 1;
        step();

        // Random phase, fixed seed
        void'($urandom(32'h5eed_0417));
        for (int blk = 0; blk < 20; blk++) begin
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom));
            for (int i = 0; i < 150; i++) begin
                cpu_rd_req = 1'($urandom);
                pci_rd_req = ($urandom % 4) == 0;
                p2x_empty  = ($urandom % 3) != 0;
                slv_commit = (($urandom % 3) == 0) && (m_cnt < CNT_CAP);
                wr_done    = (($urandom % 3) == 0) && (m_cnt > 0);
                step();
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule